// File: doc/BRIEF.md
# Multiply-Accumulate Lane with Saturating Result Extraction

This block is one multiply-accumulate lane. It multiplies two signed 16-bit operands and keeps a running sum in a 40-bit accumulator. The top eight bits of the accumulator are guard bits, so sums can grow past the 32-bit range without wrapping. Each enabled cycle does one of four operations. It can overwrite the accumulator with the product, add the product into it, form a product without touching it, or leave it alone and only re-read it.

The cycle that updates the state also records the extraction settings. After that edge, a combinational stage turns the recorded source into a 32-bit word or a 16-bit half. The source is the new accumulator value, or the bare product in multiply-only cycles. The stage always saturates. It may also round, depending on the fractional/integer flag and the rounding select.

Fractional operands are read as Q15 values, so the product is doubled. Minus one times minus one is the one product that cannot be held, and it is pinned to the largest positive word. A saturation flag shows whether the value now presented had to be clamped.

Top module: `mac_lane`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the accumulator, the extraction source and the extraction settings, so that acc_o, res_o and sat_o all read zero after that edge.
- R2: With en_i high and op_i = 2'b00 (load), acc_o after the edge equals the 32-bit signed product of a_i and b_i, sign-extended through bits 39:32.
- R3: With en_i high and op_i = 2'b01 (accumulate), acc_o after the edge equals the previous acc_o plus the sign-extended product, wrapping modulo 2^40.
- R4: With frac_i high, the product is the integer product shifted left by one bit, and 16'h8000 times 16'h8000 gives 32'h7FFFFFFF.
- R5: With en_i high and op_i = 2'b10 (multiply-only), acc_o is unchanged and the extraction source becomes the sign-extended product.
- R6: With op_i = 2'b11 (observe), acc_o is unchanged and the extraction source becomes acc_o. With en_i low, nothing changes: acc_o, res_o and sat_o hold whatever the inputs do.
- R7: With half_i low (word extraction), res_o is the source clamped to the range -2^31..2^31-1, and rnd_i has no effect.
- R8: With half_i high and frac_i high, the source is first increased by 32'h8000 if rnd_i is high. It is then clamped to 32 bits, and res_o is bits 31:16 of the clamped value, sign-extended to 32 bits.
- R9: With half_i high, frac_i low and rnd_i low, res_o is the source clamped to -32768..32767, sign-extended to 32 bits.
- R10: With half_i high, frac_i low and rnd_i high (integer round-high), 32'h8000 is added to the source, the sum is clamped to 32 bits, and res_o is bits 31:16 of the clamped value, sign-extended to 32 bits.
- R11: sat_o is high exactly when the clamp applied in R7 to R10 changed the value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Operation enable for this cycle |
| op_i | input | 2 | 00 load, 01 accumulate, 10 multiply-only, 11 observe |
| a_i | input | 16 | Signed operand A |
| b_i | input | 16 | Signed operand B |
| frac_i | input | 1 | 1 = fractional (Q15) operands, 0 = integer |
| half_i | input | 1 | 1 = extract a 16-bit half, 0 = extract a 32-bit word |
| rnd_i | input | 1 | Rounding select for half extraction |
| acc_o | output | 40 | Accumulator value |
| res_o | output | 32 | Extracted value; halves are sign-extended |
| sat_o | output | 1 | Extracted value was clamped |

## Verification
Rounding and saturation can both act on the same extraction. Adding the rounding constant can carry a value past the 32-bit limit, and the clamp must then see the rounded sum, not the original. The bench provokes this by driving the accumulator to positive and negative values past 2^31. It then extracts in round-high and rounded fractional modes, and also feeds products that sit just below the limit. Each cycle it compares res_o and sat_o with a behavioural model that rounds before it clamps, so a design that clamps first shows up as a wrong half or a missing flag.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [1:0] {
        OP_LOAD = 2'b00,
        OP_ACC  = 2'b01,
        OP_MUL  = 2'b10,
        OP_PEEK = 2'b11
    } mac_op_e;

endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
    parameter int OP_W  = 16,
    parameter int ACC_W = 40
) (
    input  logic [OP_W-1:0]         a_i,
    input  logic [OP_W-1:0]         b_i,
    input  logic                    frac_i,
    output logic signed [ACC_W-1:0] prod_o
);
    localparam int PROD_W = 2 * OP_W;
    localparam logic [PROD_W-1:0] WORD_MAX = {1'b0, {(PROD_W-1){1'b1}}};

    logic signed [PROD_W-1:0] raw_d;
    logic signed [PROD_W-1:0] word_d;

    always_comb begin
        raw_d = PROD_W'($signed(a_i)) * PROD_W'($signed(b_i));
        if (!frac_i) begin
            word_d = raw_d;
        end else if (raw_d[PROD_W-1:PROD_W-2] == 2'b01) begin
            // only min*min reaches here: doubling would flip the sign
            word_d = WORD_MAX;
        end else begin
            word_d = {raw_d[PROD_W-2:0], 1'b0};
        end
        prod_o = ACC_W'(word_d);
    end

    // R4: the single overflowing fractional product pins to the largest word
    always_comb begin
        if (frac_i && a_i == {1'b1, {(OP_W-1){1'b0}}} && b_i == {1'b1, {(OP_W-1){1'b0}}})
            p_frac_minmin_r4: assert (prod_o == ACC_W'(WORD_MAX));
    end

endmodule

// File: rtl/mac_extract.sv
module mac_extract #(
    parameter int ACC_W  = 40,
    parameter int WORD_W = 32,
    parameter int HALF_W = 16
) (
    input  logic signed [ACC_W-1:0] src_i,
    input  logic                    frac_i,
    input  logic                    half_i,
    input  logic                    rnd_i,
    output logic [WORD_W-1:0]       res_o,
    output logic                    sat_o
);
    localparam int EXT_W = ACC_W + 1;
    localparam logic signed [EXT_W-1:0] RND_K = EXT_W'(1) << (HALF_W - 1);
    localparam logic [WORD_W-1:0] W_MAX = {1'b0, {(WORD_W-1){1'b1}}};
    localparam logic [WORD_W-1:0] W_MIN = {1'b1, {(WORD_W-1){1'b0}}};
    localparam logic [HALF_W-1:0] H_MAX = {1'b0, {(HALF_W-1){1'b1}}};
    localparam logic [HALF_W-1:0] H_MIN = {1'b1, {(HALF_W-1){1'b0}}};

    logic signed [EXT_W-1:0] ext_d;
    logic signed [EXT_W-1:0] biased_d;
    logic                    fit_w_d;
    logic                    fit_h_d;
    logic [WORD_W-1:0]       word_d;
    logic [HALF_W-1:0]       hi_d;
    logic [HALF_W-1:0]       lo_d;

    always_comb begin
        ext_d    = EXT_W'(src_i);
        biased_d = ext_d + ((half_i && rnd_i) ? RND_K : '0);
        fit_w_d  = (&biased_d[EXT_W-1:WORD_W-1]) | ~(|biased_d[EXT_W-1:WORD_W-1]);
        fit_h_d  = (&ext_d[EXT_W-1:HALF_W-1]) | ~(|ext_d[EXT_W-1:HALF_W-1]);
        word_d   = fit_w_d ? biased_d[WORD_W-1:0] : (biased_d[EXT_W-1] ? W_MIN : W_MAX);
        hi_d     = word_d[WORD_W-1:WORD_W-HALF_W];
        lo_d     = fit_h_d ? ext_d[HALF_W-1:0] : (ext_d[EXT_W-1] ? H_MIN : H_MAX);

        if (!half_i) begin
            res_o = word_d;
            sat_o = !fit_w_d;
        end else if (frac_i || rnd_i) begin
            res_o = {{(WORD_W-HALF_W){hi_d[HALF_W-1]}}, hi_d};
            sat_o = !fit_w_d;
        end else begin
            res_o = {{(WORD_W-HALF_W){lo_d[HALF_W-1]}}, lo_d};
            sat_o = !fit_h_d;
        end
    end

    // R11: a flagged word is always one of the two rails
    always_comb begin
        if (sat_o && !half_i)
            p_word_rail_r11: assert (res_o == W_MAX || res_o == W_MIN);
        if (sat_o && half_i && !frac_i && !rnd_i)
            p_half_rail_r9: assert (res_o[HALF_W-1:0] == H_MAX || res_o[HALF_W-1:0] == H_MIN);
        if (half_i)
            p_half_signext_r8: assert (res_o[WORD_W-1:HALF_W] == {(WORD_W-HALF_W){res_o[HALF_W-1]}});
    end

endmodule

// File: rtl/mac_lane.sv
module mac_lane #(
    parameter int OP_W    = 16,
    parameter int GUARD_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en_i,
    input  logic [1:0]             op_i,
    input  logic [OP_W-1:0]        a_i,
    input  logic [OP_W-1:0]        b_i,
    input  logic                   frac_i,
    input  logic                   half_i,
    input  logic                   rnd_i,
    output logic [2*OP_W+GUARD_W-1:0] acc_o,
    output logic [2*OP_W-1:0]      res_o,
    output logic                   sat_o
);
    import mac_pkg::*;

    localparam int WORD_W = 2 * OP_W;
    localparam int ACC_W  = WORD_W + GUARD_W;

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
        logic signed [ACC_W-1:0] src;
        logic                    frac;
        logic                    half;
        logic                    rnd;
    } lane_st_t;

    lane_st_t                st_d, st_q;
    logic signed [ACC_W-1:0] prod_d;
    mac_op_e                 op_d;

    mac_mult #(.OP_W(OP_W), .ACC_W(ACC_W)) i_mult (
        .a_i    (a_i),
        .b_i    (b_i),
        .frac_i (frac_i),
        .prod_o (prod_d)
    );

    always_comb begin
        op_d = mac_op_e'(op_i);
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else if (en_i) begin
            st_d.frac = frac_i;
            st_d.half = half_i;
            st_d.rnd  = rnd_i;
            unique case (op_d)
                OP_LOAD: begin
                    st_d.acc = prod_d;
                    st_d.src = prod_d;
                end
                OP_ACC: begin
                    st_d.acc = st_q.acc + prod_d;
                    st_d.src = st_q.acc + prod_d;
                end
                OP_MUL: begin
                    st_d.src = prod_d;
                end
                default: begin
                    st_d.src = st_q.acc;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    mac_extract #(.ACC_W(ACC_W), .WORD_W(WORD_W), .HALF_W(OP_W)) i_extract (
        .src_i  (st_q.src),
        .frac_i (st_q.frac),
        .half_i (st_q.half),
        .rnd_i  (st_q.rnd),
        .res_o  (res_o),
        .sat_o  (sat_o)
    );

    assign acc_o = st_q.acc;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (acc_o == '0 && res_o == '0 && !sat_o));

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        (en_i && op_i == 2'b00) |=> (acc_o == $past(prod_d)));

    p_accum_r3: assert property (@(posedge clk) disable iff (rst)
        (en_i && op_i == 2'b01) |=> (acc_o == ACC_W'($past(acc_o) + $past(prod_d))));

    p_mul_keeps_acc_r5: assert property (@(posedge clk) disable iff (rst)
        (en_i && op_i == 2'b10) |=> $stable(acc_o));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> ($stable(acc_o) && $stable(res_o) && $stable(sat_o)));

endmodule

// File: tb/test_mac_lane.sv
module test_mac_lane;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [15:0] a_i = '0;
    logic [15:0] b_i = '0;
    logic        frac_i = 1'b0;
    logic        half_i = 1'b0;
    logic        rnd_i = 1'b0;
    logic [39:0] acc_o;
    logic [31:0] res_o;
    logic        sat_o;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    // model state
    longint m_acc = 0;
    longint m_src = 0;
    bit m_frac = 0, m_half = 0, m_rnd = 0;
    string acc_tag = "R1";
    string res_tag = "R1";

    mac_lane i_mac_lane (
        .clk(clk), .rst(rst), .en_i(en_i), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .frac_i(frac_i), .half_i(half_i), .rnd_i(rnd_i),
        .acc_o(acc_o), .res_o(res_o), .sat_o(sat_o)
    );

    always #10 clk = ~clk;

    function automatic longint wrap40(longint x);
        longint y;
        y = x & ((64'sd1 <<< 40) - 1);
        if (y >= (64'sd1 <<< 39)) y = y - (64'sd1 <<< 40);
        return y;
    endfunction

    function automatic longint model_prod(logic [15:0] a, logic [15:0] b, bit fr);
        longint p;
        p = longint'($signed(a)) * longint'($signed(b));
        if (fr) begin
            p = p * 2;
            if (p == 64'sd2147483648) p = 64'sd2147483647;
        end
        return p;
    endfunction

    task automatic model_extract(input longint s, input bit fr, input bit hf, input bit rd,
                                 output logic [31:0] r, output bit st);
        longint v;
        longint h;
        st = 1'b0;
        v = s;
        if (hf && rd) v = v + 32768;
        if (!hf || fr || rd) begin
            if (v > 64'sd2147483647) begin v = 64'sd2147483647; st = 1'b1; end
            if (v < -64'sd2147483648) begin v = -64'sd2147483648; st = 1'b1; end
            if (!hf) r = v[31:0];
            else begin h = v >>> 16; r = h[31:0]; end
        end else begin
            if (v > 32767) begin v = 32767; st = 1'b1; end
            if (v < -32768) begin v = -32768; st = 1'b1; end
            r = v[31:0];
        end
    endtask

    task automatic check(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // reference model update
    always @(posedge clk) begin
        longint p;
        p = model_prod(a_i, b_i, frac_i);
        if (rst) begin
            m_acc = 0; m_src = 0; m_frac = 0; m_half = 0; m_rnd = 0;
            acc_tag = "R1"; res_tag = "R1";
        end else if (!en_i) begin
            acc_tag = "R6"; res_tag = "R6";
        end else begin
            m_frac = frac_i; m_half = half_i; m_rnd = rnd_i;
            case (op_i)
                2'b00: begin m_acc = p; m_src = p; acc_tag = frac_i ? "R4" : "R2"; end
                2'b01: begin m_acc = wrap40(m_acc + p); m_src = m_acc; acc_tag = "R3"; end
                2'b10: begin m_src = p; acc_tag = "R5"; end
                default: begin m_src = m_acc; acc_tag = "R6"; end
            endcase
            if (!half_i) res_tag = "R7";
            else if (frac_i) res_tag = "R8";
            else if (rnd_i) res_tag = "R10";
            else res_tag = "R9";
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        logic [31:0] er;
        bit es;
        if (chk_on) begin
            model_extract(m_src, m_frac, m_half, m_rnd, er, es);
            check(acc_o === m_acc[39:0], acc_tag, acc_o, m_acc[39:0]);
            check(res_o === er, res_tag, {8'h0, res_o}, {8'h0, er});
            check(sat_o === es, "R11", {39'h0, sat_o}, {39'h0, es});
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles >= 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic step(input bit e, input bit [1:0] op, input logic [15:0] a, input logic [15:0] b,
                        input bit fr, input bit hf, input bit rd);
        @(negedge clk);
        rst = 1'b0; en_i = e; op_i = op; a_i = a; b_i = b;
        frac_i = fr; half_i = hf; rnd_i = rd;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R1: reset state
        check(acc_o === 40'h0, "R1", acc_o, 40'h0);
        check(res_o === 32'h0, "R1", {8'h0, res_o}, 40'h0);
        check(sat_o === 1'b0, "R1", {39'h0, sat_o}, 40'h0);
        chk_on = 1'b1;

        // R2 integer load, word extraction
        step(1, 2'b00, 16'd3, 16'hFFFC, 0, 0, 0);
        // R3 accumulate past 32 bits into guard bits, R7/R11 saturate
        step(1, 2'b00, 16'h7FFF, 16'h7FFF, 0, 0, 1);
        step(1, 2'b01, 16'h7FFF, 16'h7FFF, 0, 0, 1);
        step(1, 2'b01, 16'h7FFF, 16'h7FFF, 0, 0, 0);
        // R10 round-high on a saturating accumulator; R8 on same source
        step(1, 2'b11, 16'h0, 16'h0, 0, 1, 1);
        step(1, 2'b11, 16'h0, 16'h0, 1, 1, 1);
        step(1, 2'b11, 16'h0, 16'h0, 1, 1, 0);
        // R9 integer half clamp
        step(1, 2'b11, 16'h0, 16'h0, 0, 1, 0);
        // R6 idle with changing inputs
        step(0, 2'b00, 16'h1234, 16'h5678, 1, 0, 1);
        step(0, 2'b01, 16'h8000, 16'h8000, 0, 1, 0);
        // R5 multiply-only with R10 round-high, near-limit product
        step(1, 2'b10, 16'h7FFF, 16'h7FFF, 0, 1, 1);
        step(1, 2'b10, 16'h7FFF, 16'hFFFF, 0, 1, 0);
        // R4 fractional min*min
        step(1, 2'b00, 16'h8000, 16'h8000, 1, 0, 0);
        step(1, 2'b10, 16'h8000, 16'h8000, 1, 1, 1);
        // R8 rounding of 0.5 lsb
        step(1, 2'b10, 16'h4000, 16'h0001, 1, 1, 1);
        step(1, 2'b10, 16'h4000, 16'h0001, 1, 1, 0);
        step(1, 2'b10, 16'hC000, 16'h0001, 1, 1, 1);
        // negative saturation
        step(1, 2'b00, 16'h8000, 16'h7FFF, 0, 0, 0);
        for (int i = 0; i < 4; i++) step(1, 2'b01, 16'h8000, 16'h7FFF, 0, 0, 0);
        step(1, 2'b11, 16'h0, 16'h0, 0, 1, 1);
        step(1, 2'b11, 16'h0, 16'h0, 1, 1, 0);
        // R3 40-bit wrap: ~300 near-max fractional products
        step(1, 2'b00, 16'h0, 16'h0, 0, 0, 0);
        for (int i = 0; i < 300; i++) step(1, 2'b01, 16'h8000, 16'h8000, 1, 0, 0);
        // R1 mid-run reset
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; en_i = 1'b0;
        // random mix
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 8) != 0, 2'($urandom), 16'($urandom), 16'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom));
            if (($urandom % 97) == 0) rst = 1'b1;
        end
        @(negedge clk);
        en_i = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule